// File: doc/BRIEF.md
# Store Queue with Commit Marking and Port-Limited Writeback

This block keeps the in-flight stores of an out-of-order core in a circular buffer. Stores are given a slot in program order, receive their size, address and data when they execute, and become eligible to write to memory only once the core reports them committed. A conditional store that executes cleanly makes itself eligible at once. A writeback pointer walks ahead of the head. It sends eligible stores to the data cache over a valid/ready request channel and never spends more than a configured number of ports in one cycle. Entries leave the buffer strictly from the head, once each one has completed.

Stores of size zero and prefetch-type stores retire without a cache write. A younger-than-squash flush removes uncommitted entries from the tail end. A load that was held back behind a given store is released, through a one-cycle replay pulse that carries its load-queue index, when that store is accepted by the cache or completes. The block also reports how many new memory instructions can be dispatched, taking into account the free space of the companion load queue.

Top module: `sq_store_queue`

## Requirements
- R1: The buffer has CAPACITY+1 slots. A new store takes the slot at the tail, which `alloc_idx` shows, and slots are used in ascending order, wrapping from CAPACITY to 0. `full` is high when the slot after the tail is the head, which happens with CAPACITY stores held. An allocation is ignored while `full` or `squash_valid` is high.
- R2: Each store records the load-queue index given with its allocation. `head_ldq_idx` shows the index recorded by the oldest store.
- R3: A commit walks from the head toward the tail. It marks each not-yet-eligible entry eligible, and it stops at the first such entry whose sequence number exceeds `commit_seq`. Entries beyond that point stay ineligible even if their own number is smaller.
- R4: An executed conditional store with a nonzero size becomes eligible in the cycle after execution, without a commit. A conditional store of size zero does not.
- R5: Writeback presents the oldest eligible, unissued store on the request channel, with its slot, address, data and size. It stops at the tail or at an ineligible entry. In one cycle it uses at most WB_PORTS ports, where writes and prefetches take one port each, and it issues at most one write.
- R6: An eligible store of size zero retires without a cache request and without using a port.
- R7: An eligible prefetch-type store (`exec_pref`) uses a port and retires without a cache request.
- R8: While `wr_valid` is high and `wr_ready` is low, the request stays unchanged. The writeback pointer advances past a write only when the write is accepted.
- R9: A completion return (`cpl_valid`, `cpl_idx`) marks an issued store complete. The head frees every consecutive completed entry. A store that completes behind an uncompleted older store waits until the older store completes.
- R10: A squash walks back from the tail and removes each entry whose sequence number exceeds `squash_seq`. It stops at the first entry that is already eligible, and later allocations reuse the freed slots.
- R11: While a stall is recorded (`stall_set` latches a store sequence number and a load index), the acceptance or completion of that store raises `replay_valid` for one cycle in the following cycle, with the recorded load index.
- R12: `free_slots` equals min(`ldq_free`, CAPACITY+1 − stores held) − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a slot for a new store |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_ldq_idx | input | LDQ_IW | Load-queue tail at allocation |
| alloc_idx | output | IW | Slot the next allocation takes |
| full | output | 1 | No slot free |
| exec_valid | input | 1 | Store execute result valid |
| exec_idx | input | IW | Slot being executed |
| exec_size | input | SIZE_W | Access size in bytes, 0 means no data |
| exec_addr | input | ADDR_W | Store address |
| exec_data | input | DATA_W | Store data |
| exec_cond | input | 1 | Conditional store |
| exec_pref | input | 1 | Prefetch-type store |
| commit_valid | input | 1 | Commit notification |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Entries younger than this are removed |
| wr_valid | output | 1 | Cache write request |
| wr_ready | input | 1 | Cache accepts the request |
| wr_idx | output | IW | Slot of the request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| wr_size | output | SIZE_W | Write size |
| cpl_valid | input | 1 | Cache write completion |
| cpl_idx | input | IW | Slot that completed |
| stall_set | input | 1 | Record a stalled load |
| stall_seq | input | SEQ_W | Store the load waits for |
| stall_ldq_idx | input | LDQ_IW | Load-queue index of the stalled load |
| replay_valid | output | 1 | Replay the stalled load |
| replay_ldq_idx | output | LDQ_IW | Load to replay |
| ldq_free | input | LDQ_IW+1 | Free load-queue slots, sentinel included |
| free_slots | output | LDQ_IW+1 | Dispatchable memory instructions |
| head_ldq_idx | output | LDQ_IW | Load index recorded by the oldest store |

## Verification
A cache completion for a write at the head and the retirement of a size-zero store just behind it can both reach the head-advance logic in the same cycle. Both also decrement the pending-writeback count in that cycle. The bench sets this up as follows: a write is issued and accepted, a size-zero store behind it is committed, and the completion for the write is driven in the cycle in which the scan retires the size-zero store. It then checks that both slots are freed together. A further store is then committed, and the bench checks that it still reaches the request channel, which shows that the pending count did not underflow.

// File: rtl/sq_pkg.sv
`timescale 1ns/1ps
package sq_pkg;
  // Ring index arithmetic for a buffer of n slots.
  function automatic int unsigned sq_ring_inc(int unsigned i, int unsigned n);
    return (i + 1 >= n) ? 0 : i + 1;
  endfunction

  function automatic int unsigned sq_ring_dec(int unsigned i, int unsigned n);
    return (i == 0) ? n - 1 : i - 1;
  endfunction

  // Smaller of two free counts (each including one sentinel), less one.
  function automatic int unsigned sq_free_min(int unsigned a, int unsigned b);
    int unsigned m;
    m = (a < b) ? a : b;
    return (m == 0) ? 0 : m - 1;
  endfunction
endpackage

// File: rtl/sq_commit_scan.sv
`timescale 1ns/1ps
module sq_commit_scan
  import sq_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int SEQ_W = 16,
  localparam int IW = $clog2(SLOTS)
) (
  input  logic                        en,
  input  logic [IW-1:0]               head,
  input  logic [IW-1:0]               tail,
  input  logic [SLOTS-1:0]            wok,
  input  logic [SLOTS-1:0][SEQ_W-1:0] seq,
  input  logic [SEQ_W-1:0]            limit,
  output logic [SLOTS-1:0]            mark
);
  logic [IW-1:0] idx;
  logic          stop;

  // Walk oldest to youngest; stop at the first ineligible entry too young.
  always_comb begin
    mark = '0;
    stop = !en;
    idx  = head;
    for (int k = 0; k < SLOTS; k++) begin
      if (!stop && idx != tail) begin
        if (!wok[idx]) begin
          if (seq[idx] > limit) stop = 1'b1;
          else                  mark[idx] = 1'b1;
        end
        if (!stop) idx = IW'(sq_ring_inc(32'(idx), SLOTS));
      end else begin
        stop = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sq_squash_scan.sv
`timescale 1ns/1ps
module sq_squash_scan
  import sq_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int SEQ_W = 16,
  localparam int IW = $clog2(SLOTS),
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic                        en,
  input  logic [IW-1:0]               tail,
  input  logic [CW-1:0]               count,
  input  logic [SLOTS-1:0]            wok,
  input  logic [SLOTS-1:0][SEQ_W-1:0] seq,
  input  logic [SEQ_W-1:0]            limit,
  output logic [SLOTS-1:0]            kill,
  output logic [CW-1:0]               kill_cnt,
  output logic [IW-1:0]               tail_next
);
  logic [IW-1:0] idx;
  logic [CW-1:0] left;
  logic          stop;

  // Youngest first; an eligible (committed) entry ends the walk.
  always_comb begin
    kill      = '0;
    kill_cnt  = '0;
    tail_next = tail;
    left      = count;
    stop      = !en;
    idx       = IW'(sq_ring_dec(32'(tail), SLOTS));
    for (int k = 0; k < SLOTS; k++) begin
      if (!stop && left != '0 && seq[idx] > limit && !wok[idx]) begin
        kill[idx] = 1'b1;
        kill_cnt  = kill_cnt + 1'b1;
        tail_next = idx;
        left      = left - 1'b1;
        idx       = IW'(sq_ring_dec(32'(idx), SLOTS));
      end else begin
        stop = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sq_wb_scan.sv
`timescale 1ns/1ps
module sq_wb_scan
  import sq_pkg::*;
#(
  parameter int SLOTS    = 5,
  parameter int WB_PORTS = 2,
  localparam int IW = $clog2(SLOTS),
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic [IW-1:0]    wbp,
  input  logic [IW-1:0]    tail,
  input  logic [CW-1:0]    pend,
  input  logic [SLOTS-1:0] vld,
  input  logic [SLOTS-1:0] wok,
  input  logic [SLOTS-1:0] zero,
  input  logic [SLOTS-1:0] pref,
  input  logic             ready,
  output logic [SLOTS-1:0] retire,
  output logic [CW-1:0]    retire_cnt,
  output logic             req_valid,
  output logic [IW-1:0]    req_idx,
  output logic [IW-1:0]    wbp_next
);
  logic [IW-1:0] idx;
  logic [CW-1:0] left;
  int            used;
  logic          stop;

  always_comb begin
    retire     = '0;
    retire_cnt = '0;
    req_valid  = 1'b0;
    req_idx    = wbp;
    idx        = wbp;
    left       = pend;
    used       = 0;
    stop       = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      if (!stop) begin
        if (left != '0 && idx != tail && vld[idx] && wok[idx] && used < WB_PORTS) begin
          if (zero[idx]) begin
            // no data: retire, no port
            retire[idx] = 1'b1;
            retire_cnt  = retire_cnt + 1'b1;
            left        = left - 1'b1;
            idx         = IW'(sq_ring_inc(32'(idx), SLOTS));
          end else if (pref[idx]) begin
            // prefetch: port spent, nothing written
            retire[idx] = 1'b1;
            retire_cnt  = retire_cnt + 1'b1;
            left        = left - 1'b1;
            used        = used + 1;
            idx         = IW'(sq_ring_inc(32'(idx), SLOTS));
          end else begin
            // one real write per cycle; move on only if accepted
            req_valid = 1'b1;
            req_idx   = idx;
            used      = used + 1;
            stop      = 1'b1;
            if (ready) idx = IW'(sq_ring_inc(32'(idx), SLOTS));
          end
        end else begin
          stop = 1'b1;
        end
      end
    end
    wbp_next = idx;
  end
endmodule

// File: rtl/sq_store_queue.sv
`timescale 1ns/1ps
module sq_store_queue
  import sq_pkg::*;
#(
  parameter int CAPACITY = 4,
  parameter int WB_PORTS = 2,
  parameter int SEQ_W    = 16,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int SIZE_W   = 4,
  parameter int LDQ_IW   = 4,
  localparam int SLOTS = CAPACITY + 1,
  localparam int IW    = $clog2(SLOTS),
  localparam int CW    = $clog2(SLOTS + 1),
  localparam int LFW   = LDQ_IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic [LDQ_IW-1:0] alloc_ldq_idx,
  output logic [IW-1:0]     alloc_idx,
  output logic              full,
  input  logic              exec_valid,
  input  logic [IW-1:0]     exec_idx,
  input  logic [SIZE_W-1:0] exec_size,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic [DATA_W-1:0] exec_data,
  input  logic              exec_cond,
  input  logic              exec_pref,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [IW-1:0]     wr_idx,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [SIZE_W-1:0] wr_size,
  input  logic              cpl_valid,
  input  logic [IW-1:0]     cpl_idx,
  input  logic              stall_set,
  input  logic [SEQ_W-1:0]  stall_seq,
  input  logic [LDQ_IW-1:0] stall_ldq_idx,
  output logic              replay_valid,
  output logic [LDQ_IW-1:0] replay_ldq_idx,
  input  logic [LFW-1:0]    ldq_free,
  output logic [LFW-1:0]    free_slots,
  output logic [LDQ_IW-1:0] head_ldq_idx
);
  // ---------------- state ----------------
  logic [IW-1:0] head_q, tail_q, wbp_q;
  logic [CW-1:0] count_q, pend_q;
  logic [SLOTS-1:0] vld_q, wok_q, done_q, pref_q;
  logic [SLOTS-1:0][SEQ_W-1:0]  seq_q;
  logic [SLOTS-1:0][ADDR_W-1:0] addr_q;
  logic [SLOTS-1:0][DATA_W-1:0] data_q;
  logic [SLOTS-1:0][SIZE_W-1:0] size_q;
  logic [SLOTS-1:0][LDQ_IW-1:0] ldq_q;
  logic              stalled_q;
  logic [SEQ_W-1:0]  stall_seq_q;
  logic [LDQ_IW-1:0] stall_ldq_q;

  // ---------------- named events ----------------
  logic             alloc_fire;
  logic             wr_fire;
  logic             cond_hit;
  logic             stall_release;
  logic [SLOTS-1:0] zero_v, match_v, cond_v, cpl_v;
  logic [SLOTS-1:0] wok_pre, cmt_mark, wok_c;
  logic [SLOTS-1:0] kill, retire, done_c, free_mask;
  logic [CW-1:0]    kill_cnt, retire_cnt, free_cnt;
  logic [IW-1:0]    sq_tail, wbp_next, head_next, hw_idx;
  logic             hw_stop;
  logic [CW-1:0]    count_next, pend_next;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign zero_v[i]  = (size_q[i] == '0);
    assign match_v[i] = (seq_q[i] == stall_seq_q);
    assign cond_v[i]  = cond_hit && (exec_idx == IW'(i));
    assign cpl_v[i]   = cpl_valid && (cpl_idx == IW'(i));
  end

  assign full       = (IW'(sq_ring_inc(32'(tail_q), SLOTS)) == head_q);
  assign alloc_idx  = tail_q;
  assign alloc_fire = alloc_valid && !full && !squash_valid;
  assign cond_hit   = exec_valid && exec_cond && (exec_size != '0);
  assign wok_pre    = wok_q | cond_v;
  assign wok_c      = wok_pre | cmt_mark;

  sq_commit_scan #(.SLOTS(SLOTS), .SEQ_W(SEQ_W)) u_commit (
    .en(commit_valid), .head(head_q), .tail(tail_q), .wok(wok_pre),
    .seq(seq_q), .limit(commit_seq), .mark(cmt_mark)
  );

  sq_squash_scan #(.SLOTS(SLOTS), .SEQ_W(SEQ_W)) u_squash (
    .en(squash_valid), .tail(tail_q), .count(count_q), .wok(wok_c),
    .seq(seq_q), .limit(squash_seq), .kill(kill), .kill_cnt(kill_cnt),
    .tail_next(sq_tail)
  );

  sq_wb_scan #(.SLOTS(SLOTS), .WB_PORTS(WB_PORTS)) u_wb (
    .wbp(wbp_q), .tail(tail_q), .pend(pend_q), .vld(vld_q), .wok(wok_q),
    .zero(zero_v), .pref(pref_q), .ready(wr_ready), .retire(retire),
    .retire_cnt(retire_cnt), .req_valid(wr_valid), .req_idx(wr_idx),
    .wbp_next(wbp_next)
  );

  assign wr_addr = addr_q[wr_idx];
  assign wr_data = data_q[wr_idx];
  assign wr_size = size_q[wr_idx];
  assign wr_fire = wr_valid && wr_ready;

  // In-order release of completed entries at the head.
  assign done_c = done_q | retire | cpl_v;
  always_comb begin
    free_mask = '0;
    free_cnt  = '0;
    hw_idx    = head_q;
    hw_stop   = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      if (!hw_stop && hw_idx != tail_q && done_c[hw_idx]) begin
        free_mask[hw_idx] = 1'b1;
        free_cnt          = free_cnt + 1'b1;
        hw_idx            = IW'(sq_ring_inc(32'(hw_idx), SLOTS));
      end else begin
        hw_stop = 1'b1;
      end
    end
    head_next = hw_idx;
  end

  assign count_next = count_q + CW'(alloc_fire) - kill_cnt - free_cnt;
  assign pend_next  = pend_q + CW'($countones(cmt_mark)) + CW'(cond_hit)
                    - retire_cnt - CW'(cpl_valid);

  assign stall_release = stalled_q &&
                         ((wr_fire && match_v[wr_idx]) ||
                          (cpl_valid && match_v[cpl_idx]) ||
                          ((retire & match_v) != '0));

  assign free_slots   = LFW'(sq_free_min(32'(ldq_free), 32'(SLOTS) - 32'(count_q)));
  assign head_ldq_idx = ldq_q[head_q];

  // ---------------- control registers ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q         <= '0;
      tail_q         <= '0;
      wbp_q          <= '0;
      count_q        <= '0;
      pend_q         <= '0;
      stalled_q      <= 1'b0;
      stall_seq_q    <= '0;
      stall_ldq_q    <= '0;
      replay_valid   <= 1'b0;
      replay_ldq_idx <= '0;
    end else begin
      head_q  <= head_next;
      wbp_q   <= wbp_next;
      count_q <= count_next;
      pend_q  <= pend_next;
      if (squash_valid)    tail_q <= sq_tail;
      else if (alloc_fire) tail_q <= IW'(sq_ring_inc(32'(tail_q), SLOTS));
      replay_valid <= stall_release;
      if (stall_release) begin
        replay_ldq_idx <= stall_ldq_q;
        stalled_q      <= 1'b0;
      end
      if (stall_set) begin
        stalled_q   <= 1'b1;
        stall_seq_q <= stall_seq;
        stall_ldq_q <= stall_ldq_idx;
      end
    end
  end

  // ---------------- slot registers ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      wok_q  <= '0;
      done_q <= '0;
      pref_q <= '0;
      seq_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      size_q <= '0;
      ldq_q  <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (free_mask[i] || kill[i]) begin
          vld_q[i]  <= 1'b0;
          wok_q[i]  <= 1'b0;
          done_q[i] <= 1'b0;
        end else begin
          wok_q[i]  <= wok_c[i];
          done_q[i] <= done_c[i];
        end
        if (alloc_fire && tail_q == IW'(i)) begin
          vld_q[i]  <= 1'b1;
          wok_q[i]  <= 1'b0;
          done_q[i] <= 1'b0;
          pref_q[i] <= 1'b0;
          size_q[i] <= '0;
          seq_q[i]  <= alloc_seq;
          ldq_q[i]  <= alloc_ldq_idx;
        end
        if (exec_valid && exec_idx == IW'(i)) begin
          size_q[i] <= exec_size;
          addr_q[i] <= exec_addr;
          data_q[i] <= exec_data;
          pref_q[i] <= exec_pref;
        end
      end
    end
  end
endmodule

// File: rtl/sq_checker.sv
`timescale 1ns/1ps
module sq_checker #(
  parameter int CAPACITY = 4,
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 4,
  localparam int SLOTS = CAPACITY + 1,
  localparam int IW    = $clog2(SLOTS),
  localparam int CW    = $clog2(SLOTS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CW-1:0]     count,
  input logic [CW-1:0]     pend,
  input logic              full,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [IW-1:0]     wr_idx,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [SIZE_W-1:0] wr_size,
  input logic              stalled,
  input logic              replay_valid
);
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(CAPACITY));

  assert_full_matches_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    full == (count == CW'(CAPACITY)));

  assert_pending_within_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= count);

  assert_no_zero_size_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_size != '0);

  assert_request_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_idx) && $stable(wr_addr)));

  assert_replay_needs_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |-> $past(stalled));
endmodule

bind sq_store_queue sq_checker #(
  .CAPACITY(CAPACITY), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)
) u_sq_checker (
  .clk(clk), .rst_n(rst_n), .count(count_q), .pend(pend_q), .full(full),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx),
  .wr_addr(wr_addr), .wr_size(wr_size), .stalled(stalled_q),
  .replay_valid(replay_valid)
);

// File: tb/sq_store_queue_bench.sv
`timescale 1ns/1ps
module sq_store_queue_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 0;
  logic [15:0] alloc_seq = 0;
  logic [3:0]  alloc_ldq_idx = 0;
  logic [2:0]  alloc_idx;
  logic        full;
  logic        exec_valid = 0;
  logic [2:0]  exec_idx = 0;
  logic [3:0]  exec_size = 0;
  logic [31:0] exec_addr = 0;
  logic [31:0] exec_data = 0;
  logic        exec_cond = 0;
  logic        exec_pref = 0;
  logic        commit_valid = 0;
  logic [15:0] commit_seq = 0;
  logic        squash_valid = 0;
  logic [15:0] squash_seq = 0;
  logic        wr_valid;
  logic        wr_ready = 0;
  logic [2:0]  wr_idx;
  logic [31:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  wr_size;
  logic        cpl_valid = 0;
  logic [2:0]  cpl_idx = 0;
  logic        stall_set = 0;
  logic [15:0] stall_seq = 0;
  logic [3:0]  stall_ldq_idx = 0;
  logic        replay_valid;
  logic [3:0]  replay_ldq_idx;
  logic [4:0]  ldq_free = 5'd16;
  logic [4:0]  free_slots;
  logic [3:0]  head_ldq_idx;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sq_store_queue u_sq_store_queue (.*);

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  // All drive tasks start at a falling edge and end at the next one.
  task automatic do_alloc(input int s, input int l, output int idx);
    alloc_valid = 1; alloc_seq = 16'(s); alloc_ldq_idx = 4'(l);
    #1 idx = int'(alloc_idx);
    @(negedge clk); alloc_valid = 0;
  endtask

  task automatic do_exec(input int idx, input int sz, input int a, input int d,
                         input bit cnd, input bit pf);
    exec_valid = 1; exec_idx = 3'(idx); exec_size = 4'(sz);
    exec_addr = 32'(a); exec_data = 32'(d); exec_cond = cnd; exec_pref = pf;
    @(negedge clk); exec_valid = 0; exec_cond = 0; exec_pref = 0;
  endtask

  task automatic do_commit(input int s);
    commit_valid = 1; commit_seq = 16'(s);
    @(negedge clk); commit_valid = 0;
  endtask

  task automatic do_squash(input int s);
    squash_valid = 1; squash_seq = 16'(s);
    @(negedge clk); squash_valid = 0;
  endtask

  task automatic do_cpl(input int idx);
    cpl_valid = 1; cpl_idx = 3'(idx);
    @(negedge clk); cpl_valid = 0;
  endtask

  task automatic do_accept();
    wr_ready = 1;
    @(negedge clk); wr_ready = 0;
  endtask

  task automatic t_reset();
    check("R1 full after reset", int'(full), 0);
    check("R5 no request after reset", int'(wr_valid), 0);
    check("R11 no replay after reset", int'(replay_valid), 0);
    check("R12 free after reset", int'(free_slots), 4);
  endtask

  task automatic t_fill_squash();
    int idx;
    for (int k = 0; k < 4; k++) begin
      do_alloc(10 + k, 3 + k, idx);
      check("R1 allocation slot", idx, k);
    end
    check("R1 full at capacity", int'(full), 1);
    check("R12 free at capacity", int'(free_slots), 0);
    do_alloc(14, 8, idx);
    check("R1 allocation ignored when full", int'(free_slots), 0);
    check("R2 oldest load index", int'(head_ldq_idx), 3);
    do_squash(11);
    check("R10 squash frees two", int'(free_slots), 2);
    check("R10 not full after squash", int'(full), 0);
    do_alloc(15, 9, idx);
    check("R10 tail rewound by squash", idx, 2);
    ldq_free = 5'd2;
    #1 check("R12 load side limits", int'(free_slots), 1);
    ldq_free = 5'd16;
    @(negedge clk);
  endtask

  task automatic t_commit_write();
    do_exec(0, 4, 'h100, 'hA0, 0, 0);
    do_exec(1, 4, 'h104, 'hA1, 0, 0);
    do_exec(2, 4, 'h108, 'hA2, 0, 0);
    check("R3 nothing before commit", int'(wr_valid), 0);
    do_commit(10);
    check("R5 request after commit", int'(wr_valid), 1);
    check("R5 request slot", int'(wr_idx), 0);
    check("R5 request addr", int'(wr_addr), 'h100);
    check("R5 request data", int'(wr_data), 'hA0);
    @(negedge clk);
    check("R8 held while not ready", int'(wr_valid), 1);
    check("R8 held slot", int'(wr_idx), 0);
    do_squash(10);
    check("R10 squash stops at eligible", int'(free_slots), 3);
    check("R10 eligible store still requested", int'(wr_valid), 1);
    do_accept();
    check("R8 pointer moved on accept", int'(wr_valid), 0);
    check("R9 accepted not yet freed", int'(free_slots), 3);
    do_cpl(0);
    check("R9 completion frees head", int'(free_slots), 4);
  endtask

  task automatic t_commit_stop();
    int i1, i2, i3;
    do_alloc(20, 1, i1);
    do_alloc(21, 2, i2);
    do_alloc(22, 3, i3);
    check("R1 wrap order", i1 * 100 + i2 * 10 + i3, 123);
    do_exec(i1, 4, 'h200, 1, 0, 0);
    do_exec(i2, 4, 'h204, 2, 0, 0);
    do_exec(i3, 4, 'h208, 3, 0, 0);
    do_commit(21);
    wr_ready = 1;
    #1 check("R5 oldest first", int'(wr_idx), i1);
    @(negedge clk);
    check("R5 next write", int'(wr_idx), i2);
    @(negedge clk);
    check("R3 commit stopped at younger store", int'(wr_valid), 0);
    wr_ready = 0;
    do_cpl(i2);
    check("R9 younger completion waits", int'(free_slots), 1);
    do_cpl(i1);
    check("R9 both freed in order", int'(free_slots), 3);
    do_commit(22);
    check("R3 later commit", int'(wr_idx), i3);
    do_accept();
    do_cpl(i3);
    check("R9 empty again", int'(free_slots), 4);
  endtask

  task automatic t_zero_pref();
    int a, b, c, d;
    do_alloc(40, 0, a);
    do_alloc(41, 0, b);
    do_alloc(42, 0, c);
    do_alloc(43, 0, d);
    do_exec(a, 0, 'h0, 0, 0, 0);
    do_exec(b, 4, 'h2F0, 0, 0, 1);
    do_exec(c, 0, 'h0, 0, 0, 0);
    do_exec(d, 4, 'h300, 'h33, 0, 0);
    do_commit(43);
    check("R6 zero size uses no port", int'(wr_valid), 1);
    check("R7 prefetch not written", int'(wr_idx), d);
    check("R6 write size", int'(wr_size), 4);
    @(negedge clk);
    check("R6 R7 retired without write", int'(free_slots), 3);
    do_accept();
    do_cpl(d);
    check("R9 drained", int'(free_slots), 4);
  endtask

  task automatic t_port_limit();
    int a, b, c;
    do_alloc(50, 0, a);
    do_alloc(51, 0, b);
    do_alloc(52, 0, c);
    do_exec(a, 4, 'h3F0, 0, 0, 1);
    do_exec(b, 4, 'h3F4, 0, 0, 1);
    do_exec(c, 2, 'h400, 'h44, 0, 0);
    do_commit(52);
    check("R5 ports exhausted by prefetches", int'(wr_valid), 0);
    @(negedge clk);
    check("R5 write next cycle", int'(wr_valid), 1);
    check("R5 write slot", int'(wr_idx), c);
    check("R5 write size", int'(wr_size), 2);
    check("R5 write data", int'(wr_data), 'h44);
    do_accept();
    do_cpl(c);
    check("R7 prefetches retired", int'(free_slots), 4);
  endtask

  task automatic t_cond();
    int a, b;
    do_alloc(60, 0, a);
    do_alloc(61, 0, b);
    do_exec(a, 4, 'h500, 'h55, 1, 0);
    check("R4 conditional eligible without commit", int'(wr_valid), 1);
    check("R4 conditional slot", int'(wr_idx), a);
    do_exec(b, 0, 'h0, 0, 1, 0);
    do_squash(59);
    check("R4 zero size conditional squashed", int'(free_slots), 3);
    do_accept();
    do_cpl(a);
    check("R10 eligible store survived", int'(free_slots), 4);
  endtask

  task automatic t_stall();
    int a, b;
    do_alloc(70, 0, a);
    do_alloc(71, 0, b);
    do_exec(a, 4, 'h600, 1, 0, 0);
    do_exec(b, 4, 'h604, 2, 0, 0);
    stall_set = 1; stall_seq = 16'd70; stall_ldq_idx = 4'd7;
    @(negedge clk); stall_set = 0;
    do_commit(71);
    check("R11 no replay before issue", int'(replay_valid), 0);
    wr_ready = 1;
    @(negedge clk);
    check("R11 replay on accept", int'(replay_valid), 1);
    check("R11 replay load index", int'(replay_ldq_idx), 7);
    @(negedge clk);
    wr_ready = 0;
    check("R11 replay is one cycle", int'(replay_valid), 0);
    stall_set = 1; stall_seq = 16'd71; stall_ldq_idx = 4'd9;
    @(negedge clk); stall_set = 0;
    do_cpl(a);
    check("R11 other store no replay", int'(replay_valid), 0);
    do_cpl(b);
    check("R11 replay on completion", int'(replay_valid), 1);
    check("R11 completion load index", int'(replay_ldq_idx), 9);
    check("R9 stall stores drained", int'(free_slots), 4);
  endtask

  task automatic t_same_cycle();
    int a, b, c;
    do_alloc(80, 0, a);
    do_alloc(81, 0, b);
    do_exec(a, 4, 'h700, 7, 0, 0);
    do_exec(b, 0, 'h0, 0, 0, 0);
    do_commit(80);
    do_accept();
    check("R9 write in flight", int'(free_slots), 2);
    do_commit(81);
    do_cpl(a);
    check("R9 completion and zero retire together", int'(free_slots), 4);
    do_alloc(90, 0, c);
    do_exec(c, 4, 'h800, 8, 0, 0);
    do_commit(90);
    check("R5 pending count intact", int'(wr_valid), 1);
    check("R5 pending slot", int'(wr_idx), c);
    do_accept();
    do_cpl(c);
    check("R9 final drain", int'(free_slots), 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill_squash();
    t_commit_write();
    t_commit_stop();
    t_zero_pref();
    t_port_limit();
    t_cond();
    t_stall();
    t_same_cycle();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule